// File: doc/BRIEF.md
# Interrupt Controller Operating-Mode Sequencer

This block keeps track of which operating mode a local interrupt controller is in. Software changes the mode by writing a new pair of control bits (an enable bit and an extended-addressing bit). Two hardware events also act on it: a soft initialisation (INIT) and a full RESET. The block checks every software request against the current mode. It takes the legal ones and flags the illegal ones with a one-cycle fault pulse. It also emits a one-cycle strobe that tells the surrounding register file to return to its reset values.

The block holds the controller's identity register. That register is loaded from a 32-bit hardware-assigned physical ID on RESET, and INIT leaves it alone. The block presents the identity in the layout that suits the current mode. When extended mode is entered, it builds the logical destination ID from that identity. A small lookup gives the reset value of each register the register file asks about by selector. The register file itself lives outside.

States are named `MODE_OFF` (enable 0, extended 0), `MODE_LEGACY` (1, 0) and `MODE_EXT` (1, 1). The transitions that are taken are:

- OFF to LEGACY.
- LEGACY to OFF.
- LEGACY to EXT.
- EXT to OFF.
- Any state to LEGACY on RESET.
- Any state to itself on INIT or on a repeated write.

The rejected requests are:

- OFF to EXT.
- EXT to LEGACY.
- Any request for the pair (enable 0, extended 1).

Top module: `irq_mode_fsm`

## Requirements
- R1: The `mode` output is {enable, extended}: 2'b00 means OFF, 2'b10 means LEGACY and 2'b11 means EXT. A write requesting 2'b01 is rejected.
- R2: A RESET event (`reset_req` high at a clock edge) wins over INIT and over a write in the same cycle. After that edge, `mode` is LEGACY, the identity register holds `phys_id`, `logical_id` is 0, `regs_init` is high for one cycle and `wr_fault` is low. This holds from every state.
- R3: When a write is rejected, `wr_fault` is high for exactly the cycle after the write, and `mode` and `logical_id` do not change.
- R4: From EXT, only a write of OFF is accepted, and `logical_id` becomes 0. A write of LEGACY is rejected.
- R5: From OFF, only a write of LEGACY is accepted. A write of EXT is rejected.
- R6: From LEGACY, writes of OFF and of EXT are both accepted.
- R7: A write that repeats the current mode raises no fault and no `regs_init`, and changes nothing.
- R8: An INIT event without RESET has the following effects:
  - `mode` is unchanged.
  - `regs_init` pulses for one cycle.
  - The identity register is not reloaded.
  - A write in the same cycle is ignored: no fault and no mode change.
- R9: Entering EXT sets `logical_id` to ((id >> 4) << 16) | (1 << id[3:0]), truncated to 32 bits. INIT in EXT derives it again from the same formula. In OFF and LEGACY it is 0.
- R10: `id_view` shows the full 32-bit identity in EXT. In OFF and LEGACY it shows the identity's low 8 bits in bits 31:24, with zeros below.
- R11: `rv_value` gives the reset value for `rv_sel`, as follows:
  - Selector 0 (spurious vector) gives 0x000000FF.
  - Selector 1 (destination format) gives 0xFFFFFFFF.
  - Selectors 2 to 7 (local vector table entries) give only their mask bit, bit 16, set: 0x00010000.
  - Every other selector gives 0.
- R12: After power-on reset (`rst_n` low), `mode` is LEGACY and the identity, `logical_id`, `wr_fault` and `regs_init` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wr_valid | input | 1 | Software write of the mode bits |
| wr_enable | input | 1 | Requested enable bit |
| wr_extended | input | 1 | Requested extended-addressing bit |
| init_req | input | 1 | INIT event |
| reset_req | input | 1 | RESET event |
| phys_id | input | 32 | Hardware-assigned physical ID |
| rv_sel | input | 4 | Register selector for the reset-value lookup |
| mode | output | 2 | Current mode {enable, extended} |
| wr_fault | output | 1 | One-cycle pulse for a rejected write |
| id_view | output | 32 | Identity register in the current mode's layout |
| logical_id | output | 32 | Derived logical destination ID |
| regs_init | output | 1 | One-cycle strobe: reinitialise the register file |
| rv_value | output | 32 | Reset value for `rv_sel` |

## Verification
The hardest situation to reach is several events landing on one edge. Examples are RESET, INIT and a write together, or INIT with a write while in EXT. In those cases the priority order, not the transition table, decides the outcome. Another case is INIT in EXT after `phys_id` has changed: it must derive `logical_id` again from the stored identity, not from the live input. The directed stimulus sets up each of these collisions on purpose. A long stretch of random events, with rare INIT and RESET, then reaches the same collisions from many start states. A behavioural model checks every output on every cycle.

// File: rtl/irq_mode_pkg.sv
package irq_mode_pkg;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_LEGACY = 2'b10,
        MODE_EXT    = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ACT_STAY   = 2'b00,
        ACT_CHANGE = 2'b01,
        ACT_REJECT = 2'b10,
        ACT_SPARE  = 2'b11
    } wr_act_e;

endpackage

// File: rtl/irq_mode_next.sv
module irq_mode_next
    import irq_mode_pkg::*;
(
    input  mode_e       cur,
    input  logic [1:0]  req,
    output wr_act_e     act,
    output mode_e       nxt
);

    always_comb begin
        act = ACT_REJECT;
        nxt = cur;
        unique case (cur)
            MODE_OFF: begin
                if (req == MODE_OFF) begin
                    act = ACT_STAY;
                end else if (req == MODE_LEGACY) begin
                    act = ACT_CHANGE;
                    nxt = MODE_LEGACY;
                end
            end
            MODE_LEGACY: begin
                if (req == MODE_LEGACY) begin
                    act = ACT_STAY;
                end else if (req == MODE_OFF) begin
                    act = ACT_CHANGE;
                    nxt = MODE_OFF;
                end else if (req == MODE_EXT) begin
                    act = ACT_CHANGE;
                    nxt = MODE_EXT;
                end
            end
            MODE_EXT: begin
                if (req == MODE_EXT) begin
                    act = ACT_STAY;
                end else if (req == MODE_OFF) begin
                    act = ACT_CHANGE;
                    nxt = MODE_OFF;
                end
            end
            default: begin
                act = ACT_REJECT;
            end
        endcase
    end

endmodule

// File: rtl/irq_ldr_calc.sv
module irq_ldr_calc #(
    parameter int ID_W   = 32,
    parameter int MEMB_W = 4
) (
    input  logic [ID_W-1:0] id,
    output logic [ID_W-1:0] ldr
);

    localparam int HALF   = ID_W / 2;
    localparam int ONEHOT = 1 << MEMB_W;

    logic [HALF-1:0] member;
    logic [ID_W-1:0] cluster;

    // one-hot member position within the cluster
    for (genvar g = 0; g < HALF; g++) begin : g_member
        if (g < ONEHOT) begin : g_live
            assign member[g] = (id[MEMB_W-1:0] == MEMB_W'(g));
        end else begin : g_dead
            assign member[g] = 1'b0;
        end
    end

    assign cluster = (id >> MEMB_W) << HALF;
    assign ldr     = cluster | {{(ID_W-HALF){1'b0}}, member};

endmodule

// File: rtl/irq_rstval.sv
module irq_rstval #(
    parameter int REG_W     = 32,
    parameter int SEL_W     = 4,
    parameter int LVT_FIRST = 2,
    parameter int LVT_NUM   = 6,
    parameter int MASK_BIT  = 16,
    parameter int SPUR_RST  = 255
) (
    input  logic [SEL_W-1:0] sel,
    output logic [REG_W-1:0] val
);

    localparam logic [SEL_W-1:0] SEL_SPUR = SEL_W'(0);
    localparam logic [SEL_W-1:0] SEL_DFMT = SEL_W'(1);
    localparam logic [SEL_W-1:0] LVT_LO   = SEL_W'(LVT_FIRST);
    localparam logic [SEL_W-1:0] LVT_HI   = SEL_W'(LVT_FIRST + LVT_NUM - 1);

    always_comb begin
        if (sel == SEL_SPUR) begin
            val = REG_W'(SPUR_RST);
        end else if (sel == SEL_DFMT) begin
            val = '1;
        end else if (sel >= LVT_LO && sel <= LVT_HI) begin
            val = REG_W'(1) << MASK_BIT;
        end else begin
            val = '0;
        end
    end

endmodule

// File: rtl/irq_mode_fsm.sv
module irq_mode_fsm
    import irq_mode_pkg::*;
#(
    parameter int ID_W   = 32,
    parameter int LEG_W  = 8,
    parameter int MEMB_W = 4,
    parameter int SEL_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic             wr_enable,
    input  logic             wr_extended,
    input  logic             init_req,
    input  logic             reset_req,
    input  logic [ID_W-1:0]  phys_id,
    input  logic [SEL_W-1:0] rv_sel,
    output logic [1:0]       mode,
    output logic             wr_fault,
    output logic [ID_W-1:0]  id_view,
    output logic [ID_W-1:0]  logical_id,
    output logic             regs_init,
    output logic [ID_W-1:0]  rv_value
);

    localparam int MEMB_N = 1 << MEMB_W;

    mode_e           mode_q, mode_d;
    logic [ID_W-1:0] id_q, id_d;
    logic [ID_W-1:0] ldr_q, ldr_d;
    logic            fault_q, fault_d;
    logic            strobe_q, strobe_d;
    logic [1:0]      req;
    wr_act_e         act;
    mode_e           nxt;
    logic [ID_W-1:0] ldr_calc;

    assign req = {wr_enable, wr_extended};

    irq_mode_next u_next (
        .cur (mode_q),
        .req (req),
        .act (act),
        .nxt (nxt)
    );

    irq_ldr_calc #(.ID_W(ID_W), .MEMB_W(MEMB_W)) u_ldr (
        .id  (id_q),
        .ldr (ldr_calc)
    );

    irq_rstval #(.REG_W(ID_W), .SEL_W(SEL_W)) u_rv (
        .sel (rv_sel),
        .val (rv_value)
    );

    // next-state decision: RESET, then INIT, then software write
    always_comb begin
        mode_d   = mode_q;
        id_d     = id_q;
        ldr_d    = ldr_q;
        fault_d  = 1'b0;
        strobe_d = 1'b0;
        if (reset_req) begin
            mode_d   = MODE_LEGACY;
            id_d     = phys_id;
            ldr_d    = '0;
            strobe_d = 1'b1;
        end else if (init_req) begin
            strobe_d = 1'b1;
            ldr_d    = (mode_q == MODE_EXT) ? ldr_calc : '0;
        end else if (wr_valid) begin
            unique case (act)
                ACT_STAY: begin
                    mode_d = mode_q;
                end
                ACT_CHANGE: begin
                    mode_d = nxt;
                    if (nxt == MODE_EXT) begin
                        ldr_d = ldr_calc;
                    end else if (nxt == MODE_OFF) begin
                        ldr_d = '0;
                    end
                end
                ACT_REJECT: begin
                    fault_d = 1'b1;
                end
                ACT_SPARE: begin
                    fault_d = 1'b1;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= MODE_LEGACY;
            id_q     <= '0;
            ldr_q    <= '0;
            fault_q  <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            mode_q   <= mode_d;
            id_q     <= id_d;
            ldr_q    <= ldr_d;
            fault_q  <= fault_d;
            strobe_q <= strobe_d;
        end
    end

    // outputs
    always_comb begin
        mode       = mode_q;
        wr_fault   = fault_q;
        regs_init  = strobe_q;
        logical_id = ldr_q;
        if (mode_q == MODE_EXT) begin
            id_view = id_q;
        end else begin
            id_view = {id_q[LEG_W-1:0], {(ID_W-LEG_W){1'b0}}};
        end
    end

    // R1: the forbidden pair is refused
    assert_bad_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && req == 2'b01 && !reset_req && !init_req) |=> wr_fault);

    // R2: RESET lands in legacy with a strobe
    assert_reset_legacy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> (mode == 2'b10 && regs_init && !wr_fault && logical_id == '0));

    // R3: a fault never coincides with a mode or logical ID change
    assert_fault_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fault |-> ($stable(mode) && $stable(logical_id)));

    // R4: no direct step from extended to legacy
    assert_no_downgrade_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && wr_valid && req == 2'b10 && !reset_req && !init_req)
        |=> (wr_fault && mode == 2'b11));

    // R7: a repeated write is quiet
    assert_repeat_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && req == mode && !reset_req && !init_req)
        |=> (!wr_fault && !regs_init && $stable(mode) && $stable(logical_id)));

    // R8: INIT keeps the mode and strobes the register file
    assert_init_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (init_req && !reset_req) |=> (mode == $past(mode) && regs_init && !wr_fault));

    // R9: in extended mode exactly one member bit is set
    assert_ldr_member_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |-> ($countones(logical_id[MEMB_N-1:0]) == 1));

endmodule

// File: tb/irq_mode_fsm_test.sv
module irq_mode_fsm_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_enable = 1'b0;
    logic        wr_extended = 1'b0;
    logic        init_req = 1'b0;
    logic        reset_req = 1'b0;
    logic [31:0] phys_id = 32'h0;
    logic [3:0]  rv_sel = 4'h0;
    logic [1:0]  mode;
    logic        wr_fault;
    logic [31:0] id_view;
    logic [31:0] logical_id;
    logic        regs_init;
    logic [31:0] rv_value;

    always #10 clk = ~clk;

    irq_mode_fsm uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid    (wr_valid),
        .wr_enable   (wr_enable),
        .wr_extended (wr_extended),
        .init_req    (init_req),
        .reset_req   (reset_req),
        .phys_id     (phys_id),
        .rv_sel      (rv_sel),
        .mode        (mode),
        .wr_fault    (wr_fault),
        .id_view     (id_view),
        .logical_id  (logical_id),
        .regs_init   (regs_init),
        .rv_value    (rv_value)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    int          m_mode = 2;
    logic [31:0] m_id = 32'h0;
    logic [31:0] m_ldr = 32'h0;
    bit          m_fault = 1'b0;
    bit          m_strobe = 1'b0;

    function automatic logic [31:0] ref_ldr(input logic [31:0] id);
        logic [63:0] c;
        c = ({32'h0, id} / 64'd16) * 64'd65536;
        return c[31:0] | (32'd1 << (id % 32'd16));
    endfunction

    function automatic logic [31:0] ref_rv(input int s);
        if (s == 0) return 32'h0000_00FF;
        if (s == 1) return 32'hFFFF_FFFF;
        if (s >= 2 && s <= 7) return 32'h0001_0000;
        return 32'h0;
    endfunction

    task automatic cmp_one(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic cmp_all(input string tag);
        logic [31:0] exp_view;
        exp_view = (m_mode == 3) ? m_id : {m_id[7:0], 24'h0};
        cmp_one(tag, "mode", {30'h0, mode}, m_mode);
        cmp_one(tag, "wr_fault", {31'h0, wr_fault}, {31'h0, m_fault});
        cmp_one(tag, "regs_init", {31'h0, regs_init}, {31'h0, m_strobe});
        cmp_one(tag, "id_view", id_view, exp_view);
        cmp_one(tag, "logical_id", logical_id, m_ldr);
        cmp_one(tag, "rv_value", rv_value, ref_rv(int'(rv_sel)));
    endtask

    task automatic step(input string tag, input bit w, input logic [1:0] req,
                        input bit ini, input bit rst, input logic [31:0] pid,
                        input logic [3:0] sel);
        bit ok;
        int r;
        wr_valid    = w;
        wr_enable   = req[1];
        wr_extended = req[0];
        init_req    = ini;
        reset_req   = rst;
        phys_id     = pid;
        rv_sel      = sel;
        @(posedge clk);
        r = int'(req);
        m_fault  = 1'b0;
        m_strobe = 1'b0;
        if (rst) begin
            m_mode   = 2;
            m_id     = pid;
            m_ldr    = 32'h0;
            m_strobe = 1'b1;
        end else if (ini) begin
            m_strobe = 1'b1;
            m_ldr    = (m_mode == 3) ? ref_ldr(m_id) : 32'h0;
        end else if (w) begin
            ok = (r == m_mode) ||
                 (m_mode == 0 && r == 2) ||
                 (m_mode == 2 && (r == 0 || r == 3)) ||
                 (m_mode == 3 && r == 0);
            if (!ok) begin
                m_fault = 1'b1;
            end else if (r != m_mode) begin
                if (r == 3) m_ldr = ref_ldr(m_id);
                else if (r == 0) m_ldr = 32'h0;
                m_mode = r;
            end
        end
        @(negedge clk);
        cmp_all(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        phys_id = 32'h0000_00A5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_all("R12");

        step("R1",  1, 2'b01, 0, 0, 32'h0000_00A5, 4'd0);
        step("R2",  0, 2'b00, 0, 1, 32'h1234_5678, 4'd1);
        step("R10", 0, 2'b00, 0, 0, 32'h0, 4'd2);
        step("R6",  1, 2'b11, 0, 0, 32'h0, 4'd3);
        step("R10", 0, 2'b00, 0, 0, 32'h0, 4'd4);
        step("R4",  1, 2'b10, 0, 0, 32'h0, 4'd5);
        step("R3",  0, 2'b00, 0, 0, 32'h0, 4'd6);
        step("R7",  1, 2'b11, 0, 0, 32'h0, 4'd7);
        step("R8",  0, 2'b00, 1, 0, 32'hDEAD_BEEF, 4'd8);
        step("R8",  1, 2'b00, 1, 0, 32'hDEAD_BEEF, 4'd9);
        step("R2",  1, 2'b10, 1, 1, 32'h0000_000F, 4'd10);
        step("R6",  1, 2'b11, 0, 0, 32'h0, 4'd11);
        step("R4",  1, 2'b00, 0, 0, 32'h0, 4'd12);
        step("R5",  1, 2'b11, 0, 0, 32'h0, 4'd13);
        step("R1",  1, 2'b01, 0, 0, 32'h0, 4'd14);
        step("R7",  1, 2'b00, 0, 0, 32'h0, 4'd15);
        step("R9",  0, 2'b00, 1, 0, 32'h0, 4'd0);
        step("R5",  1, 2'b10, 0, 0, 32'h0, 4'd1);
        step("R8",  0, 2'b00, 1, 0, 32'h5555_5555, 4'd2);
        step("R6",  1, 2'b00, 0, 0, 32'h0, 4'd3);
        step("R2",  0, 2'b00, 0, 1, 32'hFFFF_FFF0, 4'd4);
        step("R9",  1, 2'b11, 0, 0, 32'h0, 4'd5);
        step("R1",  1, 2'b01, 0, 0, 32'h0, 4'd6);
        step("R9",  0, 2'b00, 1, 0, 32'h0, 4'd7);
        for (int s = 0; s < 16; s++) begin
            step("R11", 0, 2'b00, 0, 0, 32'h0, 4'(s));
        end

        for (int i = 0; i < 4000; i++) begin
            r = $urandom;
            step("random", r[0] | r[1], r[3:2], r[7:4] == 4'h0, r[11:8] == 4'h0,
                 $urandom, r[15:12]);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule